// File: doc/BRIEF.md
# Page Write Buffer and Programming Controller

This block sits behind the write-strobe qualifier of a non-volatile memory emulation. Each qualified byte write (address, data, valid) goes into a page buffer. The low `PAGE_BITS` address bits choose the byte within the page. The upper bits name the page.

A load timer restarts from zero on every accepted byte. When the timer runs out, loading closes and a programming phase of fixed length starts. During that phase the block sweeps the page in ascending offset order and drives each loaded byte onto its commit port. The commit port writes into a synchronous byte-array model held inside the block. Bytes that were not loaded keep their old contents.

While programming runs, `busy` is high and writes are refused. A read of the most recently written address returns that byte with its top bit inverted, which gives software a completion poll. Reads of any other address return zero. Once programming ends, reads return the stored contents and a new page may start.

Top module: `page_prog_ctrl`

## Requirements
- R1: While `rst_n` is low and at the first edge after release, `busy`, `page_error` and `rd_valid` are 0 and `ovf_count` is 0.
- R2: `busy` rises on the `LOAD_CYC`-th rising edge after the edge that accepted the last byte. A byte accepted on that same edge wins and restarts the count from zero.
- R3: `busy` stays high for exactly `PROG_CYC` cycles, whatever the number of loaded bytes.
- R4: During programming, each loaded offset is presented once on the commit port, in ascending order. `commit_addr` carries the latched page in its upper bits, and `commit_en` never pulses outside programming.
- R5: After programming, reads return the last value loaded at each loaded offset and the previous contents at every unloaded offset.
- R6: Every `rd_en` cycle produces exactly one `rd_valid` pulse, with `rd_data`, on the following cycle.
- R7: While `busy` is high, a read of the last accepted address returns that byte with bit `DATA_W-1` inverted and the other bits unchanged.
- R8: While `busy` is high, a read of any other address returns all zeros.
- R9: During loading, a write whose page bits differ from the first byte's page is discarded. It does not restart the load timer and it sets `page_error`, which stays set until reset.
- R10: A write during programming is discarded and never committed. Each such write raises `ovf_count` by one, up to its all-ones value, where the count stays.
- R11: After programming ends, the next write is accepted as the first byte of a new page at any page address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Qualified byte-write event |
| wr_addr | input | ADDR_W | Byte address of the write (page bits above offset bits) |
| wr_data | input | DATA_W | Byte to load |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DATA_W | Read result |
| busy | output | 1 | Programming phase active |
| page_error | output | 1 | Sticky flag for a write to a foreign page |
| ovf_count | output | OVF_W | Saturating count of writes refused while busy |
| commit_en | output | 1 | Commit strobe to the byte array |
| commit_addr | output | ADDR_W | Commit byte address |
| commit_data | output | DATA_W | Commit byte |

## Verification
The collision that matters is a byte write landing on the very edge at which the load timer would expire. The bench places a second byte exactly `LOAD_CYC` edges after the first. It expects `busy` to stay low on that edge, and then to rise a full `LOAD_CYC` edges later. A foreign-page write placed inside the window is the opposite case. It must not restart the timer, so the bench measures the shortened wait to `busy` that follows it. Reads and commits are compared through a scoreboard queue. Expected bytes are derived from the written pattern and from the polling rule.

// File: rtl/ppc_pkg.sv
// Shared types for the page programming controller.
// Assumes: nothing beyond SystemVerilog 2017.
package ppc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ppc_state_e;
endpackage

// File: rtl/ppc_page_buf.sv
// Page buffer: byte storage, per-byte loaded mask, latched page number
// and a record of the last accepted byte.
// Assumes: ld_en and clr are never high in the same cycle.
module ppc_page_buf #(
    parameter int PAGE_BITS = 7,
    parameter int PAGE_W    = 3,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic                 ld_first,
    input  logic [PAGE_BITS-1:0] ld_off,
    input  logic [PAGE_W-1:0]    ld_page,
    input  logic [DATA_W-1:0]    ld_data,
    input  logic                 clr,
    input  logic [PAGE_BITS-1:0] sel_off,
    output logic [PAGE_W-1:0]    page_q,
    output logic [PAGE_BITS-1:0] last_off,
    output logic [DATA_W-1:0]    last_data,
    output logic                 sel_mask,
    output logic [DATA_W-1:0]    sel_data
);
    localparam int PAGE = 1 << PAGE_BITS;

    logic [PAGE-1:0]   mask_q;
    logic [DATA_W-1:0] bytes_q [PAGE];

    // Byte storage: written on every accepted load, never reset.
    always_ff @(posedge clk) begin
        if (ld_en) bytes_q[ld_off] <= ld_data;
    end

    // Loaded mask, page latch and last-byte record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            page_q    <= '0;
            last_off  <= '0;
            last_data <= '0;
        end else if (clr) begin
            mask_q <= '0;
        end else if (ld_en) begin
            mask_q[ld_off] <= 1'b1;
            last_off       <= ld_off;
            last_data      <= ld_data;
            if (ld_first) page_q <= ld_page;
        end
    end

    assign sel_mask = mask_q[sel_off];
    assign sel_data = bytes_q[sel_off];
endmodule

// File: rtl/ppc_timers.sv
// Retriggerable load timer and fixed-length programming counter.
// Assumes: LOAD_CYC >= 2; load_run and prog_run are never both high.
module ppc_timers #(
    parameter int LOAD_CYC = 16,
    parameter int PROG_CYC = 200
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_restart,
    input  logic                        load_run,
    input  logic                        prog_run,
    output logic                        load_done,
    output logic [$clog2(PROG_CYC)-1:0] prog_cnt,
    output logic                        prog_last
);
    localparam int LW = $clog2(LOAD_CYC);
    localparam int PW = $clog2(PROG_CYC);

    logic [LW-1:0] load_cnt;
    logic          load_lim;

    assign load_lim  = (load_cnt == LW'(LOAD_CYC - 1));
    assign load_done = load_run && load_lim;
    assign prog_last = prog_run && (prog_cnt == PW'(PROG_CYC - 1));

    // Load window: cleared by each accepted byte, climbs to its limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                     load_cnt <= '0;
        else if (load_restart)          load_cnt <= '0;
        else if (load_run && !load_lim) load_cnt <= load_cnt + 1'b1;
    end

    // Programming duration: counts only while programming runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !prog_run) prog_cnt <= '0;
        else                     prog_cnt <= prog_cnt + 1'b1;
    end

    // R2
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_restart |=> (load_cnt == '0));
endmodule

// File: rtl/ppc_byte_array.sv
// Synchronous byte-array model: one write port, one registered read port.
// Assumes: a read and a write to the same address in one cycle return old data.
module ppc_byte_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/page_prog_ctrl.sv
// Page write buffer and programming controller.
// Collects byte writes into one page, closes loading when the
// retriggerable load timer runs out, then commits the page during a
// fixed-length programming phase while answering polls.
// Assumes: PROG_CYC > 2**PAGE_BITS, LOAD_CYC >= 2, DATA_W >= 2.
module page_prog_ctrl
    import ppc_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 7,
    parameter int LOAD_CYC  = 16,
    parameter int PROG_CYC  = 200,
    parameter int OVF_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              page_error,
    output logic [OVF_W-1:0]  ovf_count,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;
    localparam int PAGE   = 1 << PAGE_BITS;
    localparam int PCW    = $clog2(PROG_CYC);

    ppc_state_e state_q, state_d;

    logic [PAGE_W-1:0]    wr_page, page_q;
    logic [PAGE_BITS-1:0] wr_off, last_off, sweep_off;
    logic [DATA_W-1:0]    last_data, sweep_data, arr_rdata, poll_byte_q;
    logic                 accept, mismatch, drop, same_page;
    logic                 load_done, prog_last, sweep_act, mask_bit;
    logic [PCW-1:0]       prog_cnt;
    logic                 hit_last, poll_q, zero_q;

    assign wr_page   = wr_addr[ADDR_W-1:PAGE_BITS];
    assign wr_off    = wr_addr[PAGE_BITS-1:0];
    assign same_page = (wr_page == page_q);
    assign accept    = wr_valid && ((state_q == ST_IDLE) ||
                                    ((state_q == ST_LOAD) && same_page));
    assign mismatch  = wr_valid && (state_q == ST_LOAD) && !same_page;
    assign drop      = wr_valid && (state_q == ST_PROG);
    assign busy      = (state_q == ST_PROG);

    // Next-state choice; a byte on the expiry edge keeps loading open.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_LOAD;
            ST_LOAD: if (!accept && load_done) state_d = ST_PROG;
            ST_PROG: if (prog_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    ppc_timers #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_restart (accept),
        .load_run     (state_q == ST_LOAD),
        .prog_run     (busy),
        .load_done    (load_done),
        .prog_cnt     (prog_cnt),
        .prog_last    (prog_last)
    );

    ppc_page_buf #(.PAGE_BITS(PAGE_BITS), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (accept),
        .ld_first  (state_q == ST_IDLE),
        .ld_off    (wr_off),
        .ld_page   (wr_page),
        .ld_data   (wr_data),
        .clr       (prog_last),
        .sel_off   (sweep_off),
        .page_q    (page_q),
        .last_off  (last_off),
        .last_data (last_data),
        .sel_mask  (mask_bit),
        .sel_data  (sweep_data)
    );

    assign sweep_off   = prog_cnt[PAGE_BITS-1:0];
    assign sweep_act   = busy && (prog_cnt < PCW'(PAGE));
    assign commit_en   = sweep_act && mask_bit;
    assign commit_addr = {page_q, sweep_off};
    assign commit_data = sweep_data;

    ppc_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk   (clk),
        .we    (commit_en),
        .waddr (commit_addr),
        .wdata (commit_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    assign hit_last = (rd_addr == {page_q, last_off});

    // Read response selection, aligned with the array's read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            poll_q      <= 1'b0;
            zero_q      <= 1'b0;
            poll_byte_q <= '0;
        end else begin
            rd_valid    <= rd_en;
            poll_q      <= rd_en && busy && hit_last;
            zero_q      <= rd_en && busy && !hit_last;
            poll_byte_q <= {~last_data[DATA_W-1], last_data[DATA_W-2:0]};
        end
    end

    assign rd_data = poll_q ? poll_byte_q : (zero_q ? '0 : arr_rdata);

    // Sticky foreign-page flag and saturating refusal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_error <= 1'b0;
            ovf_count  <= '0;
        end else begin
            if (mismatch) page_error <= 1'b1;
            if (drop && (ovf_count != '1)) ovf_count <= ovf_count + 1'b1;
        end
    end

    // R6
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R6
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R4
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> busy);
    // R9
    page_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_error |=> page_error);
    // R10
    ovf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_valid && (ovf_count != '1)) |=> (ovf_count == $past(ovf_count) + 1'b1));
    // R2
    no_prog_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOAD) && accept) |=> !busy);
    // R3
    prog_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(prog_last));
endmodule

// File: tb/page_prog_ctrl_bench.sv
module page_prog_ctrl_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int PB     = 7;
    localparam int LOAD_CYC = 16;
    localparam int PROG_CYC = 200;
    localparam int OVF_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic rd_valid, busy, page_error, commit_en;
    logic [DATA_W-1:0] rd_data, commit_data;
    logic [OVF_W-1:0] ovf_count;
    logic [ADDR_W-1:0] commit_addr;

    int nchk = 0;
    int nfail = 0;
    int commit_cnt = 0;
    int run_len = 0;
    int last_len = 0;
    bit prev_busy = 1'b0;
    logic [ADDR_W-PB-1:0] exp_page = '0;
    logic [DATA_W-1:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    page_prog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PB),
                     .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .OVF_W(OVF_W)) u_page_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .page_error(page_error), .ovf_count(ovf_count),
        .commit_en(commit_en), .commit_addr(commit_addr), .commit_data(commit_data));

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] pollv(input logic [7:0] d);
        return {~d[7], d[6:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_valid = 1'b1;
        wr_addr  = ADDR_W'(a);
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input int a, input logic [7:0] e, input string tag);
        rd_en   = 1'b1;
        rd_addr = ADDR_W'(a);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
        check("R6 pending reads", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (!busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    endtask

    // Scoreboard monitor: pops one expected byte per read response.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 32'(rd_data), 32'(e));
            end
        end
    end

    // Commit monitor and busy-length measurement.
    always @(negedge clk) begin
        if (rst_n && commit_en) begin
            commit_cnt++;
            check("R4 commit page", 32'(commit_addr[ADDR_W-1:PB]), 32'(exp_page));
        end
        if (busy) run_len++;
        else if (prev_busy) begin
            last_len = run_len;
            run_len = 0;
        end
        prev_busy = busy;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 page_error in reset", 32'(page_error), 32'd0);
        check("R1 ovf_count in reset", 32'(ovf_count), 32'd0);
        check("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", 32'(busy), 32'd0);

        // Full page 0
        exp_page = '0;
        commit_cnt = 0;
        for (int i = 0; i < 128; i++) wr(i, pat(i));
        wait_busy(n);
        check("R2 load timeout full page", 32'(n), 32'(LOAD_CYC));
        rd(127, pollv(pat(127)), "R7 poll last byte");
        rd(5, 8'h00, "R8 other address while busy");
        wr(300, 8'hEE);
        check("R10 ovf after one refusal", 32'(ovf_count), 32'd1);
        wait_idle();
        check("R4 commits full page", 32'(commit_cnt), 32'd128);
        check("R3 busy length full page", 32'(last_len), 32'(PROG_CYC));
        rd(0, pat(0), "R5 full page byte 0");
        rd(5, pat(5), "R5 full page byte 5");
        rd(127, pat(127), "R5 full page byte 127");
        drain();

        // Partial page 0 with rewrite, foreign page, refusals
        commit_cnt = 0;
        wr(3, 8'h11);
        wr(10, 8'h22);
        wr(3, 8'h33);
        repeat (2) @(negedge clk);
        wr(5 * 128 + 1, 8'h44);
        check("R9 page_error set", 32'(page_error), 32'd1);
        wait_busy(n);
        check("R9 foreign write no restart", 32'(n), 32'(LOAD_CYC - 3));
        rd(3, pollv(8'h33), "R7 poll after rewrite");
        wr(20, 8'hEE);
        for (int k = 0; k < 7; k++) wr(40 + k, 8'h99);
        check("R10 ovf saturates", 32'(ovf_count), 32'd7);
        wait_idle();
        check("R4 commits partial page", 32'(commit_cnt), 32'd2);
        check("R3 busy length partial page", 32'(last_len), 32'(PROG_CYC));
        rd(3, 8'h33, "R5 last value wins");
        rd(10, 8'h22, "R5 loaded byte");
        rd(4, pat(4), "R5 unloaded byte kept");
        rd(20, pat(20), "R10 refused write not committed");
        drain();
        check("R9 page_error sticky", 32'(page_error), 32'd1);

        // Page 1, second byte on the expiry edge
        exp_page = 3'd1;
        commit_cnt = 0;
        wr(128, 8'h5C);
        repeat (LOAD_CYC - 1) @(negedge clk);
        check("R11 new page loading, not busy", 32'(busy), 32'd0);
        wr(137, 8'h6D);
        check("R2 byte on expiry edge wins", 32'(busy), 32'd0);
        wait_busy(n);
        check("R2 restart from expiry edge", 32'(n), 32'(LOAD_CYC));
        wait_idle();
        check("R11 commits new page", 32'(commit_cnt), 32'd2);
        rd(128, 8'h5C, "R11 new page byte 0");
        rd(137, 8'h6D, "R2 late byte committed");
        drain();

        summary();
        $finish;
    end
endmodule